// File: doc/BRIEF.md
# Return-From-Exception Status Unit

This block owns the condition-code status word and the stack-pointer bank of a processor core. It applies the status changes that a return-from-exception instruction needs. The status word holds a packed stack of interrupt-state frames. A return pulse pops one frame by shifting the word right, and the top two bits stay where they are. If the frame brought back is in user mode, the active stack pointer is saved as the kernel stack pointer and is then loaded from the user stack pointer. The pending-store flag is then set, unless the restored state has its R flag set.

The core writes the status word, the stack pointer and the user stack pointer through plain write strobes. A separate check strobe asks whether a conditional store may go ahead. The answer comes back in the same cycle, and it is a failure whenever the pending flag is set. Instruction fetch and the jump to the return address belong to the pipeline, not to this block.

Top module: `rfe_status_unit`

## Requirements
- R1: After reset, the status word, stack pointer, user stack pointer and kernel stack pointer all read zero.
- R2: On a clock edge with `rfe_i` high, the status word becomes the old bits 31:30 in bits 31:30, zeros in bits 29:18, and the old bits 27:10 in bits 17:0. Old bits 29:28 and 9:0 are lost. Bit 7 is then adjusted as R4 states.
- R3: If old status bit 16 is set, that bit being the user flag at bit 6 after the shift, then the same rfe edge loads `ksp_o` with the old `sp_o` and loads `sp_o` with the old `usp_o`.
- R4: After the rfe shift, the pending flag at bit 7 is forced to 1 when the R flag at bit 8 is 0, which is old bit 18. When that bit is 1, bit 7 keeps the shifted value, which is old bit 17.
- R5: An rfe whose restored user flag is 0 leaves `sp_o` and `ksp_o` unchanged, unless `sp_we_i` writes `sp_o`.
- R6: `st_fail_o` is combinational and equals `st_chk_i` AND status bit 7. In an rfe cycle it uses the status value from before that edge.
- R7: With `rfe_i` low, `ccs_we_i`, `sp_we_i` and `usp_we_i` each load their register from the matching write-data port on the next edge.
- R8: In an rfe cycle the rfe update of the status word takes priority over `ccs_we_i`. A stack-pointer swap takes priority over `sp_we_i`. `usp_we_i` still takes effect.
- R9: With no strobe asserted, all registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rfe_i | input | 1 | Return-from-exception pulse |
| ccs_we_i | input | 1 | Status word write enable |
| ccs_wdata_i | input | 32 | Status word write data |
| sp_we_i | input | 1 | Stack pointer write enable |
| sp_wdata_i | input | 32 | Stack pointer write data |
| usp_we_i | input | 1 | User stack pointer write enable |
| usp_wdata_i | input | 32 | User stack pointer write data |
| st_chk_i | input | 1 | Conditional store check strobe |
| ccs_o | output | 32 | Status word |
| sp_o | output | 32 | Active stack pointer |
| usp_o | output | 32 | User stack pointer |
| ksp_o | output | 32 | Saved kernel stack pointer |
| st_fail_o | output | 1 | Conditional store failed |

## Verification
The assertions check on every cycle that an rfe keeps the top bits, clears the gap bits and forces the pending flag when R is clear. They also check that a user-mode return swaps the pointers, that a kernel-mode return leaves them alone, and that the registers hold when no strobe is asserted. The bench scenarios show the exact movement of the frame bits and the pending flag when R is set. They also show the collisions between rfe and the write strobes, and that a store check in an rfe cycle uses the status value from before the update.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
  localparam int FLG_C = 0;
  localparam int FLG_V = 1;
  localparam int FLG_Z = 2;
  localparam int FLG_N = 3;
  localparam int FLG_X = 4;
  localparam int FLG_I = 5;
  localparam int FLG_U = 6;
  localparam int FLG_P = 7;
  localparam int FLG_R = 8;
  localparam int FLG_S = 9;
endpackage

// File: rtl/rfe_ccs_pop.sv
module rfe_ccs_pop
  import rfe_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FRAME_W = 10,
  parameter int KEEP_W  = 2,
  parameter int GAP_W   = 2
) (
  input  logic [DATA_W-1:0] ccs_i,
  output logic [DATA_W-1:0] ccs_o,
  output logic              user_o
);
  localparam int LOW_W   = DATA_W - KEEP_W;
  localparam int STACK_W = LOW_W - GAP_W;

  logic [STACK_W-1:0] stack;
  logic [LOW_W-1:0]   shifted;

  assign stack   = ccs_i[STACK_W-1:0] >> FRAME_W;
  assign shifted = LOW_W'(stack);

  always_comb begin
    ccs_o = {ccs_i[DATA_W-1 -: KEEP_W], shifted};
    if (!ccs_o[FLG_R]) ccs_o[FLG_P] = 1'b1;
  end

  assign user_o = ccs_o[FLG_U];
endmodule

// File: rtl/rfe_sp_bank.sv
module rfe_sp_bank #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              swap_i,
  input  logic              sp_we_i,
  input  logic [DATA_W-1:0] sp_wdata_i,
  input  logic              usp_we_i,
  input  logic [DATA_W-1:0] usp_wdata_i,
  output logic [DATA_W-1:0] sp_o,
  output logic [DATA_W-1:0] usp_o,
  output logic [DATA_W-1:0] ksp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_o  <= '0;
      usp_o <= '0;
      ksp_o <= '0;
    end else begin
      if (swap_i) begin
        ksp_o <= sp_o;
        sp_o  <= usp_o;
      end else if (sp_we_i) begin
        sp_o <= sp_wdata_i;
      end
      if (usp_we_i) usp_o <= usp_wdata_i;
    end
  end
endmodule

// File: rtl/rfe_store_chk.sv
module rfe_store_chk (
  input  logic st_chk_i,
  input  logic pend_i,
  output logic fail_o
);
  assign fail_o = st_chk_i & pend_i;
endmodule

// File: rtl/rfe_status_unit.sv
module rfe_status_unit
  import rfe_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FRAME_W = 10,
  parameter int KEEP_W  = 2,
  parameter int GAP_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rfe_i,
  input  logic              ccs_we_i,
  input  logic [DATA_W-1:0] ccs_wdata_i,
  input  logic              sp_we_i,
  input  logic [DATA_W-1:0] sp_wdata_i,
  input  logic              usp_we_i,
  input  logic [DATA_W-1:0] usp_wdata_i,
  input  logic              st_chk_i,
  output logic [DATA_W-1:0] ccs_o,
  output logic [DATA_W-1:0] sp_o,
  output logic [DATA_W-1:0] usp_o,
  output logic [DATA_W-1:0] ksp_o,
  output logic              st_fail_o
);
  logic [DATA_W-1:0] ccs_q, ccs_pop;
  logic              user_ret;

  rfe_ccs_pop #(
    .DATA_W(DATA_W), .FRAME_W(FRAME_W), .KEEP_W(KEEP_W), .GAP_W(GAP_W)
  ) u_pop (
    .ccs_i (ccs_q),
    .ccs_o (ccs_pop),
    .user_o(user_ret)
  );

  // rfe wins over a software write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ccs_q <= '0;
    else if (rfe_i)    ccs_q <= ccs_pop;
    else if (ccs_we_i) ccs_q <= ccs_wdata_i;
  end

  rfe_sp_bank #(.DATA_W(DATA_W)) u_sp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .swap_i     (rfe_i & user_ret),
    .sp_we_i    (sp_we_i),
    .sp_wdata_i (sp_wdata_i),
    .usp_we_i   (usp_we_i),
    .usp_wdata_i(usp_wdata_i),
    .sp_o       (sp_o),
    .usp_o      (usp_o),
    .ksp_o      (ksp_o)
  );

  rfe_store_chk u_st (
    .st_chk_i(st_chk_i),
    .pend_i  (ccs_q[FLG_P]),
    .fail_o  (st_fail_o)
  );

  assign ccs_o = ccs_q;
endmodule

// File: rtl/rfe_status_chk.sv
module rfe_status_chk
  import rfe_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rfe_i,
  input logic              ccs_we_i,
  input logic              sp_we_i,
  input logic              usp_we_i,
  input logic              st_chk_i,
  input logic [DATA_W-1:0] ccs_o,
  input logic [DATA_W-1:0] sp_o,
  input logic [DATA_W-1:0] usp_o,
  input logic [DATA_W-1:0] ksp_o,
  input logic              st_fail_o
);
  p_top_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfe_i |=> ccs_o[31:30] == $past(ccs_o[31:30]));

  p_gap_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfe_i |=> ccs_o[29:18] == '0);

  p_swap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfe_i && ccs_o[16]) |=> (sp_o == $past(usp_o)) && (ksp_o == $past(sp_o)));

  p_pend_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfe_i && !ccs_o[18]) |=> ccs_o[FLG_P]);

  p_no_swap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfe_i && !ccs_o[16] && !sp_we_i) |=> $stable(sp_o) && $stable(ksp_o));

  p_fail_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_chk_i |-> !st_fail_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rfe_i && !ccs_we_i && !sp_we_i && !usp_we_i) |=>
      $stable(ccs_o) && $stable(sp_o) && $stable(usp_o) && $stable(ksp_o));
endmodule

bind rfe_status_unit rfe_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rfe_i    (rfe_i),
  .ccs_we_i (ccs_we_i),
  .sp_we_i  (sp_we_i),
  .usp_we_i (usp_we_i),
  .st_chk_i (st_chk_i),
  .ccs_o    (ccs_o),
  .sp_o     (sp_o),
  .usp_o    (usp_o),
  .ksp_o    (ksp_o),
  .st_fail_o(st_fail_o)
);

// File: tb/rfe_status_unit_bench.sv
module rfe_status_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rfe = 1'b0, ccs_we = 1'b0, sp_we = 1'b0, usp_we = 1'b0, st_chk = 1'b0;
  logic [31:0] ccs_wd = '0, sp_wd = '0, usp_wd = '0;
  logic [31:0] ccs, sp, usp, ksp;
  logic        st_fail;

  logic [31:0] m_ccs = '0, m_sp = '0, m_usp = '0, m_ksp = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rfe_status_unit u_rfe_status_unit (
    .clk_i(clk), .rst_ni(rst_n), .rfe_i(rfe),
    .ccs_we_i(ccs_we), .ccs_wdata_i(ccs_wd),
    .sp_we_i(sp_we), .sp_wdata_i(sp_wd),
    .usp_we_i(usp_we), .usp_wdata_i(usp_wd),
    .st_chk_i(st_chk),
    .ccs_o(ccs), .sp_o(sp), .usp_o(usp), .ksp_o(ksp), .st_fail_o(st_fail)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // model update for one edge
  task automatic model_edge();
    logic [31:0] n;
    logic [27:0] low;
    if (rfe) begin
      low = m_ccs[27:0] >> 10;
      n = {m_ccs[31:30], 2'b00, low};
      if (n[8] == 1'b0) n[7] = 1'b1;
      if (n[6]) begin
        m_ksp = m_sp;
        m_sp  = m_usp;
      end else if (sp_we) m_sp = sp_wd;
      m_ccs = n;
    end else begin
      if (ccs_we) m_ccs = ccs_wd;
      if (sp_we)  m_sp  = sp_wd;
    end
    if (usp_we) m_usp = usp_wd;
  endtask

  // one cycle: inputs already set at negedge
  task automatic cyc(input string req);
    #1;
    chk("R6 st_fail", {31'b0, st_fail}, {31'b0, st_chk & m_ccs[7]});
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk({req, " ccs"}, ccs, m_ccs);
    chk({req, " sp"}, sp, m_sp);
    chk({req, " usp"}, usp, m_usp);
    chk({req, " ksp"}, ksp, m_ksp);
  endtask

  task automatic idle();
    rfe = 0; ccs_we = 0; sp_we = 0; usp_we = 0; st_chk = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ccs", ccs, 32'h0);
    chk("R1 sp", sp, 32'h0);
    chk("R1 usp", usp, 32'h0);
    chk("R1 ksp", ksp, 32'h0);
    rst_n = 1;
    @(negedge clk);

    // R7 writes
    idle(); ccs_we = 1; ccs_wd = 32'hC001_0000; sp_we = 1; sp_wd = 32'h1000;
    usp_we = 1; usp_wd = 32'h2000;
    cyc("R7");
    idle(); cyc("R9");

    // R3 user return: old bit16 set, bit18 clear -> P forced (R4)
    idle(); rfe = 1; cyc("R3");
    chk("R2 top", {30'b0, ccs[31:30]}, 32'h3);
    chk("R4 P forced", {31'b0, ccs[7]}, 32'h1);
    chk("R3 sp", sp, 32'h2000);
    chk("R3 ksp", ksp, 32'h1000);

    // R4 R set, P shifted 0 -> stays 0 ; kernel return R5
    idle(); ccs_we = 1; ccs_wd = 32'h3FFC_0000 & ~32'h0003_0000 | 32'h0004_0000;
    sp_we = 1; sp_wd = 32'h3000; cyc("R7");
    idle(); rfe = 1; cyc("R4");
    chk("R4 P kept", {31'b0, ccs[7]}, 32'h0);
    chk("R2 gap", {20'b0, ccs[29:18]}, 32'h0);
    chk("R5 sp", sp, 32'h3000);

    // R6 store check with P set, and during rfe using pre-update value
    idle(); ccs_we = 1; ccs_wd = 32'h0000_0080; cyc("R7");
    idle(); st_chk = 1; cyc("R6");
    idle(); ccs_we = 1; ccs_wd = 32'h0; cyc("R7");
    idle(); st_chk = 1; rfe = 1; cyc("R6");
    chk("R6 post P", {31'b0, ccs[7]}, 32'h1);

    // R8 collisions
    idle(); ccs_we = 1; ccs_wd = 32'h0001_0000; usp_we = 1; usp_wd = 32'h5000; cyc("R7");
    idle(); rfe = 1; ccs_we = 1; ccs_wd = 32'hFFFF_FFFF; sp_we = 1; sp_wd = 32'h7777;
    usp_we = 1; usp_wd = 32'h6000; cyc("R8");
    chk("R8 sp from usp", sp, 32'h5000);
    chk("R8 usp", usp, 32'h6000);

    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      rfe = ($urandom % 4) == 0;
      ccs_we = $urandom % 2; ccs_wd = $urandom;
      sp_we = $urandom % 2;  sp_wd = $urandom;
      usp_we = $urandom % 2; usp_wd = $urandom;
      st_chk = $urandom % 2;
      cyc("R2");
    end
    idle(); cyc("R9");
    finish_run();
  end
endmodule